// File: doc/BRIEF.md
# Edge-Detecting General-Purpose I/O Controller

This block controls 28 general-purpose pins from a simple register bus. Each pin can be an output, driven from an output latch, or an input. Software changes single latch bits through separate write-one set and write-one clear ports, so no read-modify-write is needed. Input pins pass through a two-flop synchronizer. Rising or falling transitions on enabled input pins are recorded in a sticky edge-status register, and software clears that register by writing ones.

Pins 0 to 10 each have a dedicated interrupt line that follows their own status bit. Pins 11 to 27 share one interrupt line, which is the OR of their status bits. An alternate-function register is provided as storage only. Pad drivers and alternate-function muxing sit outside the block.

Register map, as 3-bit word addresses:
- 0: direction
- 1: set port
- 2: clear port
- 3: rising-edge enable
- 4: falling-edge enable
- 5: alternate function
- 6: pin level (read only)
- 7: edge status

Writes take effect at the clock edge that samples `wr_en`. Reads are combinational on `addr`.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0, all pins are inputs (`pin_oe` = 0), `pin_out` is 0 and every interrupt output is low.
- R2: Direction register (address 0): a bit of 1 makes that pin an output. `pin_oe` equals the direction register. `pin_out` carries the output latch bit on output pins and 0 on input pins.
- R3: Writing to the set port (address 1) ORs `wdata` into the output latch. Reading address 1 returns the last value written there.
- R4: Writing to the clear port (address 2) clears the latch bits where `wdata` is 1. Reading address 2 returns 0.
- R5: The level readback (address 6) returns the latch bit for output pins and the synchronized input for input pins. A change on `pin_in` appears there after the second rising clock edge.
- R6: Rising-edge enable (address 3): a 0-to-1 transition on an input pin whose enable is 1 sets that pin's status bit (address 7). The bit is set at the third rising clock edge after `pin_in` changes.
- R7: Falling-edge enable (address 4): a 1-to-0 transition on an input pin whose enable is 1 sets the status bit. A transition whose matching enable is 0 leaves the status unchanged.
- R8: A pin whose direction bit is 1 never sets its status bit, whatever its input does.
- R9: Writing to address 7 clears the status bits where `wdata` is 1 and leaves the others. If a new edge arrives in the same cycle as the clearing write, the bit stays set.
- R10: `irq_pin[i]` equals status bit i for i = 0 to 10. `irq_shared` is the OR of status bits 11 to 27.
- R11: The alternate-function register (address 5) reads back what was written and has no effect on `pin_out`, `pin_oe` or the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 28 | Write data |
| rdata | output | 28 | Read data for `addr` (combinational) |
| pin_in | input | 28 | Asynchronous pin input levels |
| pin_out | output | 28 | Pin output levels, 0 where released |
| pin_oe | output | 28 | Pin output enables |
| irq_pin | output | 11 | Per-pin interrupts for pins 0 to 10 |
| irq_shared | output | 1 | Shared interrupt for pins 11 to 27 |

## Verification
Register writes and their effect on `pin_out`, `pin_oe` and the interrupts become visible one edge after the write strobe is sampled. The bench therefore samples at the falling edge that follows. A change on `pin_in` reaches the level readback after two edges, and reaches the status register and interrupts after three. The bench drives pins at a falling edge and samples two or three edges later, and also checks once that the status is still clear after only two edges. The case of a clearing write racing a new edge is built by issuing the write so that it is sampled on exactly the third edge after the pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  typedef enum logic [2:0] {
    REG_DIR    = 3'd0,
    REG_SET    = 3'd1,
    REG_CLR    = 3'd2,
    REG_RISE   = 3'd3,
    REG_FALL   = 3'd4,
    REG_ALT    = 3'd5,
    REG_LEVEL  = 3'd6,
    REG_STATUS = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= 2'b00;
    else           chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_out = chain_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 28,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  gpio_reg_e           addr,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] latch_q,
  output logic [NUM_PINS-1:0] set_shadow_q,
  output logic [NUM_PINS-1:0] rise_q,
  output logic [NUM_PINS-1:0] fall_q,
  output logic [NUM_PINS-1:0] alt_q
);
  logic we_dir, we_set, we_clr, we_rise, we_fall, we_alt;
  logic [NUM_PINS-1:0] latch_d;

  always_comb begin
    we_dir  = wr_en && (addr == REG_DIR);
    we_set  = wr_en && (addr == REG_SET);
    we_clr  = wr_en && (addr == REG_CLR);
    we_rise = wr_en && (addr == REG_RISE);
    we_fall = wr_en && (addr == REG_FALL);
    we_alt  = wr_en && (addr == REG_ALT);
    latch_d = latch_q;
    if (we_set) latch_d = latch_q | wdata;
    if (we_clr) latch_d = latch_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q        <= '0;
      latch_q      <= '0;
      set_shadow_q <= '0;
      rise_q       <= '0;
      fall_q       <= '0;
      alt_q        <= '0;
    end else begin
      if (we_dir)            dir_q        <= wdata;
      if (we_set || we_clr)  latch_q      <= latch_d;
      if (we_set)            set_shadow_q <= wdata;
      if (we_rise)           rise_q       <= wdata;
      if (we_fall)           fall_q       <= wdata;
      if (we_alt)            alt_q        <= wdata;
    end
  end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int NUM_PINS = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] sync_lvl,
  input  logic [NUM_PINS-1:0] dir,
  input  logic [NUM_PINS-1:0] rise_en,
  input  logic [NUM_PINS-1:0] fall_en,
  input  logic                clr_we,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] status_q
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] keep;
  logic [NUM_PINS-1:0] status_d;

  always_comb begin
    hit      = ~dir & ((sync_lvl & ~prev_q & rise_en) |
                       (~sync_lvl & prev_q & fall_en));
    keep     = clr_we ? (status_q & ~clr_mask) : status_q;
    status_d = keep | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sync_lvl;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int NUM_PINS   = 28,
  parameter int NUM_DIRECT = 11
) (
  input  logic [NUM_PINS-1:0]   status,
  output logic [NUM_DIRECT-1:0] irq_pin,
  output logic                  irq_shared
);
  for (genvar g = 0; g < NUM_DIRECT; g++) begin : g_direct
    assign irq_pin[g] = status[g];
  end
  assign irq_shared = |status[NUM_PINS-1:NUM_DIRECT];
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS    = 28,
  parameter int NUM_DIRECT  = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            addr,
  input  logic [NUM_PINS-1:0]   wdata,
  output logic [NUM_PINS-1:0]   rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_DIRECT-1:0] irq_pin,
  output logic                  irq_shared
);
  gpio_reg_e           reg_sel;
  logic                rst_n_int;
  logic [NUM_PINS-1:0] sync_lvl;
  logic [NUM_PINS-1:0] dir_q, latch_q, set_shadow_q, rise_q, fall_q, alt_q;
  logic [NUM_PINS-1:0] status_q;
  logic [NUM_PINS-1:0] level;
  logic                status_we;

  assign reg_sel   = gpio_reg_e'(addr);
  assign status_we = wr_en && (reg_sel == REG_STATUS);

  gpio_rst_sync u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_int)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .din(pin_in), .dout(sync_lvl)
  );

  gpio_ctrl_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .addr(reg_sel),
    .wdata(wdata), .dir_q(dir_q), .latch_q(latch_q),
    .set_shadow_q(set_shadow_q), .rise_q(rise_q), .fall_q(fall_q),
    .alt_q(alt_q)
  );

  gpio_edge_status #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n_int), .sync_lvl(sync_lvl), .dir(dir_q),
    .rise_en(rise_q), .fall_en(fall_q), .clr_we(status_we),
    .clr_mask(wdata), .status_q(status_q)
  );

  gpio_irq_route #(.NUM_PINS(NUM_PINS), .NUM_DIRECT(NUM_DIRECT)) u_irq (
    .status(status_q), .irq_pin(irq_pin), .irq_shared(irq_shared)
  );

  assign level   = (latch_q & dir_q) | (sync_lvl & ~dir_q);
  assign pin_out = latch_q & dir_q;
  assign pin_oe  = dir_q;

  always_comb begin
    case (reg_sel)
      REG_DIR:    rdata = dir_q;
      REG_SET:    rdata = set_shadow_q;
      REG_CLR:    rdata = '0;
      REG_RISE:   rdata = rise_q;
      REG_FALL:   rdata = fall_q;
      REG_ALT:    rdata = alt_q;
      REG_LEVEL:  rdata = level;
      REG_STATUS: rdata = status_q;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 28
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [2:0]          addr,
  input logic [NUM_PINS-1:0] wdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] latch_q
);
  // R2: output enables change only through a direction write
  a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'(REG_DIR)) |=> $stable(pin_oe));

  // R3: set port ORs its data into the latch
  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'(REG_SET)) |=> ((latch_q & $past(wdata)) == $past(wdata)));

  // R4: clear port removes its data bits from the latch
  a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'(REG_CLR)) |=> ((latch_q & $past(wdata)) == '0));

  // R8: no new status bit on a pin that was an output
  a_r8_out_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & $past(pin_oe)) == '0));

  // R9: status bits stay sticky without a clearing write
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'(REG_STATUS)) |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pin_oe(pin_oe), .status_q(status_q), .latch_q(latch_q)
);

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
  localparam int NP = 28;
  localparam int ND = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [NP-1:0] wdata = '0;
  logic [NP-1:0] rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [ND-1:0] irq_pin;
  logic          irq_shared;

  int checks = 0;
  int errors = 0;
  logic [NP-1:0] rv;

  always #4 clk = ~clk;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_pin(irq_pin), .irq_shared(irq_shared)
  );

  task automatic chk(input string req, input logic [NP-1:0] got,
                     input logic [NP-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [NP-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic chk_irq(input string req, input logic [NP-1:0] st);
    chk(req, NP'(irq_pin), NP'(st[ND-1:0]));
    chk(req, NP'(irq_shared), NP'(|st[NP-1:ND]));
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    edges(2);
    rst_n = 1'b1;
    edges(3);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv); chk("R1 reset read", rv, '0);
    end
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    chk_irq("R1 irq", '0);

    // R2 R3 R4 walking latch bits on all-output pins
    wr(3'd0, '1);
    chk("R2 oe", pin_oe, '1);
    for (int i = 0; i < NP; i++) begin
      wr(3'd1, NP'(1) << i);
      chk("R3 set bit", pin_out, NP'(1) << i);
      rd(3'd1, rv); chk("R3 set readback", rv, NP'(1) << i);
      wr(3'd2, NP'(1) << i);
      chk("R4 clr bit", pin_out, '0);
    end
    rd(3'd2, rv); chk("R4 clr reads zero", rv, '0);
    wr(3'd1, 28'h5A5A5A5);
    wr(3'd1, 28'h0000F00);
    chk("R3 set accumulates", pin_out, 28'h5A5AFA5);
    wr(3'd2, 28'h000000F);
    chk("R4 partial clear", pin_out, 28'h5A5AFA0);
    wr(3'd0, 28'h00FF00F);
    chk("R2 release", pin_out, 28'h5A5AFA0 & 28'h00FF00F);
    chk("R2 oe follows", pin_oe, 28'h00FF00F);

    // R5 level readback mix and two-edge latency
    pin_in = 28'hF0F0F0F;
    edges(1);
    rd(3'd6, rv); chk("R5 not yet", rv, 28'h5A5AFA0 & 28'h00FF00F);
    edges(1);
    rd(3'd6, rv);
    chk("R5 level", rv, (28'h5A5AFA0 & 28'h00FF00F) | (28'hF0F0F0F & ~28'h00FF00F));
    pin_in = '0;
    wr(3'd0, '0);
    edges(3);
    wr(3'd7, '1);

    // R11 alternate function storage only
    wr(3'd5, 28'hABCDEF1);
    rd(3'd5, rv); chk("R11 alt readback", rv, 28'hABCDEF1);
    chk("R11 no pin effect", pin_out, '0);
    chk("R11 no oe effect", pin_oe, '0);
    rd(3'd7, rv); chk("R11 no status effect", rv, '0);

    // R6 latency: still clear after two edges
    wr(3'd3, 28'h1);
    pin_in[0] = 1'b1;
    edges(2);
    rd(3'd7, rv); chk("R6 early", rv, '0);
    edges(1);
    rd(3'd7, rv); chk("R6 on third edge", rv, 28'h1);
    pin_in[0] = 1'b0;
    edges(3);
    wr(3'd7, '1);

    // R6 R7 R10 sweep every pin and enable combination
    for (int i = 0; i < NP; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [NP-1:0] b, er, ef;
        b  = NP'(1) << i;
        er = m[0] ? b : '0;
        ef = m[1] ? b : '0;
        wr(3'd3, er);
        wr(3'd4, ef);
        pin_in = b;
        edges(3);
        rd(3'd7, rv); chk("R6 rising sweep", rv, er);
        chk_irq("R10 rising irq", er);
        wr(3'd7, '1);
        rd(3'd7, rv); chk("R9 cleared", rv, '0);
        pin_in = '0;
        edges(3);
        rd(3'd7, rv); chk("R7 falling sweep", rv, ef);
        chk_irq("R10 falling irq", ef);
        wr(3'd7, '1);
      end
    end

    // R8 outputs record no edges
    wr(3'd3, '1);
    wr(3'd4, '1);
    wr(3'd0, '1);
    pin_in = '1;
    edges(3);
    rd(3'd7, rv); chk("R8 rise on output", rv, '0);
    rd(3'd6, rv); chk("R5 output level from latch", rv, 28'h5A5AFA0);
    pin_in = '0;
    edges(3);
    rd(3'd7, rv); chk("R8 fall on output", rv, '0);
    wr(3'd0, '0);
    edges(3);
    rd(3'd7, rv); chk("R8 no spurious on turnaround", rv, '0);

    // R9 selective clear
    pin_in = 28'h8000803;
    edges(3);
    rd(3'd7, rv); chk("R9 setup", rv, 28'h8000803);
    chk_irq("R10 mixed", 28'h8000803);
    wr(3'd7, 28'h0000801);
    rd(3'd7, rv); chk("R9 partial clear", rv, 28'h8000002);
    chk_irq("R10 after partial", 28'h8000002);
    wr(3'd7, '1);

    // R9 new edge in the same cycle as the clear wins
    pin_in = 28'h0;
    edges(2);
    wr(3'd7, 28'h0000001);
    rd(3'd7, rv); chk("R9 edge beats clear", rv, 28'h8000803);
    wr(3'd7, '1);
    rd(3'd7, rv); chk("R9 clear all", rv, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule